// File: doc/BRIEF.md
# Hard-Decision Trellis Decoder for a Four-State Rate-1/3 Code

This block recovers information bits from a noisy stream of 3-bit hard-decision symbols produced by a four-state, rate-1/3 convolutional encoder. The symbols are assumed to have crossed a binary symmetric channel. The frame format is fixed. A frame carries a programmable number of information steps followed by two flush steps, and the flush steps return the encoder to the all-zero state. For every received symbol the decoder forms Hamming branch metrics and updates four running path metrics with add-compare-select. It also stores one survivor decision bit per state.

After the last symbol of a frame, the decoder walks the survivor memory backwards from the all-zero state. It then replays the recovered information bits in their original order, one bit per cycle, and reports the accumulated Hamming distance of the chosen codeword. A new frame begins with a `start` pulse that carries its length. Symbols arrive with `sym_valid` and may have idle cycles between them.

State numbering is as follows. Bit 0 of a state index holds the most recent input bit and bit 1 holds the input before it. Taking input `u` in state `s` leads to state `{s[0], u}`.

Top module: `vit_decoder`

## Requirements
- R1: While `rst` is high and after it is released, `busy`, `bit_valid`, `done` and `path_metric` are all zero.
- R2: The branch metric is the number of differing bits between `sym` and the transition's code word. `sym[2]` is the first code bit. The code words, written as (from state, input) → word, are: (0,0)→000, (0,1)→111, (1,0)→101, (1,1)→010, (2,0)→011, (2,1)→100, (3,0)→110, (3,1)→001. A frame received without errors decodes with metric 0. A frame with one flipped bit decodes with metric 1.
- R3: State 0 starts a frame at metric 0, and every other state starts unreachable. Each state keeps the incoming path of smallest accumulated metric. When two paths have equal metrics, the predecessor with the lower state index is kept.
- R4: During the final two symbols of a frame, only input-0 transitions are allowed. Traceback starts from state 0, so the output bits are those of the minimum-distance path that ends in state 0.
- R5: `path_metric` equals the state-0 metric after the last symbol and holds until the next accepted `start`. For the received sequence 110 110 110 111 010 101 101 with 5 information steps, the decoder outputs bits 1,1,0,0,1 and a metric of 7.
- R6: The decoder outputs exactly n information bits, oldest first, on n consecutive cycles with `bit_valid` high. The first bit appears 2·(n+2)+1 clock edges after the edge that accepted the last symbol.
- R7: `done` is high for one cycle, in the same cycle as the last `bit_valid`. `busy` falls on that same edge.
- R8: `sym_valid` and `start` have no effect while the decoder is tracing back or outputting bits.
- R9: An `info_len` of 0 is treated as 1. A value above MAX_INFO is treated as MAX_INFO.
- R10: Cycles with `sym_valid` low during a frame do not advance the trellis.
- R11: The metric registers are wide enough for 3·(MAX_INFO+2), so `path_metric` never reaches its all-ones saturation value at the end of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame when idle |
| info_len | input | IW | Number of information steps for the frame |
| sym_valid | input | 1 | `sym` carries a received symbol |
| sym | input | 3 | Hard-decision received symbol, first code bit in bit 2 |
| busy | output | 1 | A frame is in progress |
| bit_valid | output | 1 | `bit_out` carries a decoded bit |
| bit_out | output | 1 | Decoded information bit |
| done | output | 1 | Marks the last decoded bit of the frame |
| path_metric | output | MW | Final state-0 path metric of the last frame |

## Verification
Two events can land in the same cycle. The final decoded bit and the end-of-frame flag share one cycle, and the bench checks that `done` never shows up without `bit_valid`, that no bit is left pending when it does, and that `busy` has already dropped. The second collision is with input activity after the last symbol. Right after that symbol, the bench deliberately drives extra `sym_valid` pulses and a fresh `start` with a different length while traceback runs. It then judges the bit stream, the metric and the return to idle against an independent software trellis search, to show that these inputs collided harmlessly with the traceback.

// File: rtl/vit_pkg.sv
package vit_pkg;

  localparam int NSTATE = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_ACC, PH_TB, PH_OUT} phase_t;

  // code word emitted when leaving from_st with input in_bit
  function automatic logic [2:0] edge_code(input logic [1:0] from_st, input logic in_bit);
    logic [2:0] w;
    case ({from_st, in_bit})
      3'b000: w = 3'b000;
      3'b001: w = 3'b111;
      3'b010: w = 3'b101;
      3'b011: w = 3'b010;
      3'b100: w = 3'b011;
      3'b101: w = 3'b100;
      3'b110: w = 3'b110;
      default: w = 3'b001;
    endcase
    return w;
  endfunction

  function automatic logic [1:0] code_dist(input logic [2:0] a, input logic [2:0] b);
    logic [2:0] x;
    x = a ^ b;
    return {1'b0, x[0]} + {1'b0, x[1]} + {1'b0, x[2]};
  endfunction

endpackage

// File: rtl/vit_acs.sv
module vit_acs #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] pm_a,
  input  logic [MW-1:0] pm_b,
  input  logic [1:0]    bm_a,
  input  logic [1:0]    bm_b,
  input  logic          block,
  output logic [MW-1:0] pm_out,
  output logic          pick_b
);
  localparam logic [MW-1:0] INF = '1;

  logic [MW:0]   sum_a, sum_b;
  logic [MW-1:0] sat_a, sat_b;

  always_comb begin
    sum_a = {1'b0, pm_a} + {{(MW-1){1'b0}}, bm_a};
    sum_b = {1'b0, pm_b} + {{(MW-1){1'b0}}, bm_b};
    sat_a = (sum_a >= {1'b0, INF}) ? INF : sum_a[MW-1:0];
    sat_b = (sum_b >= {1'b0, INF}) ? INF : sum_b[MW-1:0];
    pick_b = (sat_b < sat_a);
    if (block)       pm_out = INF;
    else if (pick_b) pm_out = sat_b;
    else             pm_out = sat_a;
  end
endmodule

// File: rtl/vit_surv_mem.sv
module vit_surv_mem #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/vit_decoder.sv
module vit_decoder
  import vit_pkg::*;
#(
  parameter int MAX_INFO = 32,
  localparam int MAX_STEPS = MAX_INFO + 2,
  localparam int IW = $clog2(MAX_STEPS + 1),
  localparam int MW = $clog2(3 * MAX_STEPS + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] info_len,
  input  logic          sym_valid,
  input  logic [2:0]    sym,
  output logic          busy,
  output logic          bit_valid,
  output logic          bit_out,
  output logic          done,
  output logic [MW-1:0] path_metric
);
  localparam int TAIL = 2;
  localparam logic [MW-1:0] INF = '1;
  localparam logic [IW-1:0] MAX_N = IW'(MAX_INFO);

  phase_t          phase;
  logic [IW-1:0]   n_info, step, tb_idx, out_idx, len_c;
  logic [1:0]      tb_state;
  logic            tb_use;
  logic [MW-1:0]   pm    [NSTATE];
  logic [MW-1:0]   pm_nx [NSTATE];
  logic [NSTATE-1:0] dec_nx, rd_dec;
  logic            in_tail, acc_fire;
  logic            bit_buf [2**IW];

  assign in_tail  = (step >= n_info);
  assign acc_fire = (phase == PH_ACC) && sym_valid;
  assign busy     = (phase != PH_IDLE);

  always_comb begin
    if (info_len == '0)        len_c = IW'(1);
    else if (info_len > MAX_N) len_c = MAX_N;
    else                       len_c = info_len;
  end

  // one ACS per destination state; predecessors are {0,t[1]} and {1,t[1]}
  for (genvar t = 0; t < NSTATE; t++) begin : g_acs
    localparam logic [1:0] TS = 2'(t);
    localparam logic [1:0] PA = {1'b0, TS[1]};
    localparam logic [1:0] PB = {1'b1, TS[1]};
    logic [1:0] bm_a, bm_b;
    assign bm_a = code_dist(edge_code(PA, TS[0]), sym);
    assign bm_b = code_dist(edge_code(PB, TS[0]), sym);
    vit_acs #(.MW(MW)) u_acs (
      .pm_a   (pm[PA]),
      .pm_b   (pm[PB]),
      .bm_a   (bm_a),
      .bm_b   (bm_b),
      .block  (in_tail && TS[0]),
      .pm_out (pm_nx[t]),
      .pick_b (dec_nx[t])
    );
  end

  vit_surv_mem #(.AW(IW), .DW(NSTATE)) u_mem (
    .clk     (clk),
    .wr_en   (acc_fire),
    .wr_addr (step),
    .wr_data (dec_nx),
    .rd_en   ((phase == PH_TB) && !tb_use),
    .rd_addr (tb_idx),
    .rd_data (rd_dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_IDLE;
      n_info      <= '0;
      step        <= '0;
      tb_idx      <= '0;
      out_idx     <= '0;
      tb_state    <= '0;
      tb_use      <= 1'b0;
      bit_valid   <= 1'b0;
      bit_out     <= 1'b0;
      done        <= 1'b0;
      path_metric <= '0;
      for (int s = 0; s < NSTATE; s++) pm[s] <= '0;
    end else begin
      bit_valid <= 1'b0;
      done      <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          n_info <= len_c;
          step   <= '0;
          for (int s = 0; s < NSTATE; s++) pm[s] <= (s == 0) ? MW'(0) : INF;
          phase  <= PH_ACC;
        end
        PH_ACC: if (sym_valid) begin
          for (int s = 0; s < NSTATE; s++) pm[s] <= pm_nx[s];
          step <= step + IW'(1);
          if (step == n_info + IW'(TAIL - 1)) begin
            phase       <= PH_TB;
            path_metric <= pm_nx[0];
            tb_idx      <= step;
            tb_state    <= '0;
            tb_use      <= 1'b0;
          end
        end
        PH_TB: begin
          if (!tb_use) begin
            tb_use <= 1'b1;
          end else begin
            tb_use <= 1'b0;
            if (tb_idx < n_info) bit_buf[tb_idx] <= tb_state[0];
            tb_state <= {rd_dec[tb_state], tb_state[1]};
            if (tb_idx == '0) begin
              phase   <= PH_OUT;
              out_idx <= '0;
            end else begin
              tb_idx <= tb_idx - IW'(1);
            end
          end
        end
        PH_OUT: begin
          bit_valid <= 1'b1;
          bit_out   <= bit_buf[out_idx];
          if (out_idx == n_info - IW'(1)) begin
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else begin
            out_idx <= out_idx + IW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vit_decoder_chk.sv
module vit_decoder_chk #(
  parameter int MW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          bit_valid,
  input logic          done,
  input logic [MW-1:0] path_metric
);
  // R6: a decoded bit outside the final cycle only while a frame runs
  p_bit_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !done) |-> busy);

  // R7: end flag rides on the last bit and the frame has closed
  p_done_with_bit_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (bit_valid && !busy));

  // R7: end flag lasts a single cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: start while idle opens a frame
  p_start_opens_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R5: reported metric holds while idle with no new frame
  p_metric_held_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(path_metric));

  // R11: final metric never saturates
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (path_metric != '1));
endmodule

bind vit_decoder vit_decoder_chk #(.MW(MW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .busy        (busy),
  .bit_valid   (bit_valid),
  .done        (done),
  .path_metric (path_metric)
);

// File: tb/tb_vit_decoder.sv
module tb_vit_decoder;
  localparam int MAX_INFO  = 32;
  localparam int MAX_STEPS = MAX_INFO + 2;
  localparam int IW = $clog2(MAX_STEPS + 1);
  localparam int MW = $clog2(3 * MAX_STEPS + 2);
  localparam int BIG = 1000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [IW-1:0] info_len = '0;
  logic sym_valid = 1'b0;
  logic [2:0] sym = '0;
  wire busy, bit_valid, bit_out, done;
  wire [MW-1:0] path_metric;

  always #5 clk = ~clk;

  vit_decoder #(.MAX_INFO(MAX_INFO)) dut (
    .clk(clk), .rst(rst), .start(start), .info_len(info_len),
    .sym_valid(sym_valid), .sym(sym), .busy(busy), .bit_valid(bit_valid),
    .bit_out(bit_out), .done(done), .path_metric(path_metric)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rx [64];
  int info [64];
  int exp_bits [$];
  int exp_metric, steps, last_cyc, got_bits, got_val;
  bit saw_done = 0, first_seen = 0, mon_on = 0;
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lab(input int s, input int u);
    int a, b;
    a = s & 1; b = (s >> 1) & 1;
    return ((u ^ a) << 2) | ((u ^ b) << 1) | (u ^ a ^ b);
  endfunction

  function automatic int hd3(input int x, input int y);
    int d;
    d = x ^ y;
    return (d & 1) + ((d >> 1) & 1) + ((d >> 2) & 1);
  endfunction

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  task automatic encode(input int n);
    int st, u;
    st = 0;
    for (int k = 0; k < n + 2; k++) begin
      u = (k < n) ? info[k] : 0;
      rx[k] = lab(st, u);
      st = ((st & 1) << 1) | u;
    end
  endtask

  // behavioural search: relax every edge, strict improvement keeps lower source on ties
  task automatic ref_decode(input int n);
    int pm [4];
    int nm [4];
    int pred [64][4];
    int bits [64];
    int t, c, st;
    pm = '{0, BIG, BIG, BIG};
    for (int k = 0; k < n + 2; k++) begin
      nm = '{BIG, BIG, BIG, BIG};
      for (int s = 0; s < 4; s++)
        for (int u = 0; u < 2; u++) begin
          if ((k >= n && u == 1) || pm[s] >= BIG) continue;
          t = ((s & 1) << 1) | u;
          c = pm[s] + hd3(lab(s, u), rx[k]);
          if (c < nm[t]) begin nm[t] = c; pred[k][t] = s; end
        end
      pm = nm;
    end
    exp_metric = pm[0];
    st = 0;
    for (int k = n + 1; k >= 0; k--) begin
      bits[k] = st & 1;
      st = pred[k][st];
    end
    exp_bits.delete();
    for (int k = 0; k < n; k++) exp_bits.push_back(bits[k]);
  endtask

  always @(negedge clk) begin
    int e;
    if (mon_on) begin
      if (bit_valid) begin
        if (!first_seen) begin
          first_seen = 1;
          check(cyc - last_cyc == 2 * steps + 1, "R6", "first bit latency", cyc - last_cyc, 2 * steps + 1);
        end
        if (exp_bits.size() > 0) begin
          e = exp_bits.pop_front();
          check(int'(bit_out) == e, "R4", "decoded bit", int'(bit_out), e);
        end else begin
          check(0, "R6", "surplus bit", got_bits + 1, got_bits);
        end
        got_bits++;
        got_val = (got_val << 1) | int'(bit_out);
      end
      if (done) begin
        saw_done = 1;
        check(bit_valid, "R7", "done without bit", int'(bit_valid), 1);
        check(exp_bits.size() == 0, "R7", "bits pending at done", exp_bits.size(), 0);
        check(!busy, "R7", "busy at done", int'(busy), 0);
        check(int'(path_metric) == exp_metric, "R5", "final metric", int'(path_metric), exp_metric);
      end
    end
  end

  task automatic run_frame(input int req_len, input int n, input int gap, input bit disturb);
    int w;
    ref_decode(n);
    steps = n + 2;
    first_seen = 0; saw_done = 0; got_bits = 0; got_val = 0;
    mon_on = 1;
    @(negedge clk);
    start = 1'b1; info_len = IW'(req_len);
    @(negedge clk);
    start = 1'b0;
    check(busy, "R8", "busy after start", int'(busy), 1);
    for (int k = 0; k < steps; k++) begin
      sym_valid = 1'b1; sym = 3'(rx[k]);
      @(negedge clk);
      last_cyc = cyc;
      sym_valid = 1'b0; sym = 3'b000;
      if (k < steps - 1) for (int g = 0; g < gap; g++) @(negedge clk);  // R10 idle gaps
    end
    if (disturb) begin
      for (int d = 0; d < 5; d++) begin
        sym_valid = 1'b1; sym = 3'(rnd()); start = 1'b1; info_len = IW'(3);
        @(negedge clk);
      end
      sym_valid = 1'b0; start = 1'b0;
    end
    w = 0;
    while (!saw_done && w < 2000) begin @(negedge clk); w++; end
    if (!saw_done) check(0, "R7", "watchdog, no done", 0, 1);
    repeat (3) @(negedge clk);
    mon_on = 0;
    check(got_bits == n, "R6", "bit count", got_bits, n);
    check(!busy, "R8", "idle after frame", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy, "R1", "busy in reset", int'(busy), 0);
    check(!bit_valid, "R1", "bit_valid in reset", int'(bit_valid), 0);
    check(!done, "R1", "done in reset", int'(done), 0);
    check(path_metric == '0, "R1", "metric in reset", int'(path_metric), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !bit_valid && !done, "R1", "outputs after reset", int'(busy), 0);

    // R5 worked example
    rx[0] = 6; rx[1] = 6; rx[2] = 6; rx[3] = 7; rx[4] = 2; rx[5] = 5; rx[6] = 5;
    run_frame(5, 5, 0, 0);
    check(got_val == 25, "R5", "example bits 11001", got_val, 25);
    check(int'(path_metric) == 7, "R5", "example metric", int'(path_metric), 7);

    // R2 clean frame
    for (int k = 0; k < 8; k++) info[k] = (k * 5 + 1) % 3 == 0 ? 1 : (k & 1);
    encode(8);
    run_frame(8, 8, 0, 0);
    check(path_metric == '0, "R2", "clean metric", int'(path_metric), 0);

    // R2 single flipped bit
    rx[3] = rx[3] ^ 2;
    run_frame(8, 8, 1, 0);
    check(int'(path_metric) == 1, "R2", "one-error metric", int'(path_metric), 1);

    // R10 noisy frame with idle gaps
    for (int k = 0; k < 12; k++) info[k] = rnd() & 1;
    encode(12);
    for (int k = 0; k < 14; k++) if (rnd() % 4 == 0) rx[k] = rx[k] ^ (1 << (rnd() % 3));
    run_frame(12, 12, 2, 0);

    // boundary: one information step
    info[0] = 1; encode(1);
    run_frame(1, 1, 0, 0);

    // R9 zero length acts as one
    info[0] = 0; encode(1); rx[1] = 3;
    run_frame(0, 1, 0, 0);

    // R3 ties: constant received word
    for (int k = 0; k < 12; k++) rx[k] = 7;
    run_frame(10, 10, 0, 0);

    // R8 traffic during traceback ignored
    for (int k = 0; k < 6; k++) info[k] = (k == 2 || k == 5) ? 1 : 0;
    encode(6); rx[1] = rx[1] ^ 4;
    run_frame(6, 6, 0, 1);

    // R9 over-long length clamps, with disturbance
    for (int k = 0; k < MAX_INFO; k++) info[k] = rnd() & 1;
    encode(MAX_INFO);
    for (int k = 0; k < MAX_STEPS; k++) if (rnd() % 5 == 0) rx[k] = rx[k] ^ (1 << (rnd() % 3));
    run_frame(40, MAX_INFO, 0, 1);

    // R11 every code bit inverted at maximum length
    for (int k = 0; k < MAX_INFO; k++) info[k] = (k % 3 == 0) ? 1 : 0;
    encode(MAX_INFO);
    for (int k = 0; k < MAX_STEPS; k++) rx[k] = rx[k] ^ 7;
    run_frame(MAX_INFO, MAX_INFO, 0, 0);
    check(path_metric != '1, "R11", "metric not saturated", int'(path_metric), exp_metric);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL R7 global watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule